// File: doc/BRIEF.md
# SDRAM Bank Geometry Probe

This block sizes a single external SDRAM bank by exploiting address aliasing. The bank controller is assumed to be set up beforehand for its widest decode (11 column bits, 4 internal banks). On a start pulse the probe acts as a bus master. It writes a byte-replicated tag to each of nine "wrap" addresses, four on the column side and five on the row side. When a device has fewer column bits, row bits or internal banks than the widest setting, a later write lands on the same cell as an earlier one and overwrites its tag.

Every write is read back at once to confirm the bank answers at all. After the nine pairs, three more reads show which tag survived at three places: the row-12 address, which gives the internal-bank count, the row-14 address, which gives the row mask, and the column-11 address, which gives the column count. From these three words the probe builds a 4-bit configuration nibble and an ending-address byte for the bank, or it reports the bank as unusable.

The memory port is a plain request/ready handshake of one word per transfer. A transfer completes in the cycle where `mem_req` and `mem_ready` are both high, and read data is taken in that same cycle.

Top module: `geo_probe`

## Requirements
- R1: A probe issues, in order, a write then a read-back at each of these address/tag pairs: 0x0e001e00/0x0b0b0b0b, 0x0e000e00/0x0a0a0a0a, 0x0e000600/0x09090909, 0x0e000200/0x08080808, 0x0f000000/0x3f3f3f3f, 0x07000000/0x1f1f1f1f, 0x03000000/0x0f0f0f0f, 0x01000000/0x07070707, 0x00000000/0xaaaaaaaa. It then issues three plain reads at 0x03000000, 0x0f000000 and 0x0e001e00, for 21 transfers in total. `mem_we` is 1 for writes only.
- R2: While `mem_req` is high and `mem_ready` is low, the request and its address, direction and write data stay unchanged into the next cycle.
- R3: If a read-back differs from the tag just written, the bank is bad and no further transfer is issued for that probe. After a failure at pair k (counted from 0), exactly 2(k+1) transfers have been made.
- R4: The word read at 0x03000000 decides the internal-bank count. 0xaaaaaaaa means 2 banks. 0x07070707 or 0x0f0f0f0f means 4 banks. Any other value makes the bank bad.
- R5: The word read at 0x0f000000 (the row mask) must be, as an unsigned number, within 0x07070707 to 0x3f3f3f3f inclusive, and its four bytes must be equal. Otherwise the bank is bad.
- R6: The word read at 0x0e001e00 must be within 0x08080808 to 0x0b0b0b0b inclusive with all four bytes equal. Otherwise the bank is bad. The column code is its byte minus 8, giving a value from 0 to 3.
- R7: For a good bank, `cfg_nibble` holds the 4-bank flag in bit 3, 0 in bit 2 and the column code in bits 1:0.
- R8: For a good bank, `end_byte` is the row-mask byte shifted right by 2 (4 banks) or by 3 (2 banks), plus one.
- R9: For a bad bank, `cfg_nibble` and `end_byte` are both zero.
- R10: `result_valid` is high for exactly one cycle per probe, with `bad`, `cfg_nibble` and `end_byte` valid in that cycle. These three hold their values until the next result, and no transfer is pending while `result_valid` is high.
- R11: After reset, `mem_req`, `result_valid` and `bad` are low, and `cfg_nibble` and `end_byte` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a probe when the block is idle |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, sampled when the transfer completes |
| mem_ready | input | 1 | Completes the pending transfer |
| result_valid | output | 1 | One-cycle result strobe |
| bad | output | 1 | Bank failed sizing |
| cfg_nibble | output | 4 | {4-bank flag, 0, column code} |
| end_byte | output | 8 | Ending-address byte for the bank |

## Verification
An error in the step counter or the phase bit shows up at the memory port at once. The address or the write/read direction goes wrong on the very transfer where the state diverges, so a per-transfer comparison of the whole trace catches it within one handshake. An error in a captured word or in the decode only shows up in the single `result_valid` cycle, as a wrong `cfg_nibble`, `end_byte` or `bad`. The sweep therefore covers every column/row/bank combination of an aliasing memory model, plus injected read values at each decision boundary.

// File: rtl/geo_probe_pkg.sv
package geo_probe_pkg;

  localparam int ADDR_W     = 32;
  localparam int NUM_VERIFY = 9;   // write + read-back pairs
  localparam int NUM_FINAL  = 3;   // decision reads
  localparam int NUM_STEPS  = NUM_VERIFY + NUM_FINAL;
  localparam int STEP_W     = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_WRITE,
    PS_READ,
    PS_DONE
  } probe_state_e;

  // Step order is behaviour: each later write may alias onto an earlier one.
  function automatic logic [ADDR_W-1:0] step_addr(input logic [STEP_W-1:0] idx);
    case (idx)
      4'd0:    step_addr = 32'h0e00_1e00;
      4'd1:    step_addr = 32'h0e00_0e00;
      4'd2:    step_addr = 32'h0e00_0600;
      4'd3:    step_addr = 32'h0e00_0200;
      4'd4:    step_addr = 32'h0f00_0000;
      4'd5:    step_addr = 32'h0700_0000;
      4'd6:    step_addr = 32'h0300_0000;
      4'd7:    step_addr = 32'h0100_0000;
      4'd9:    step_addr = 32'h0300_0000;  // bank-count read
      4'd10:   step_addr = 32'h0f00_0000;  // row-mask read
      4'd11:   step_addr = 32'h0e00_1e00;  // column read
      default: step_addr = 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [7:0] step_tag(input logic [STEP_W-1:0] idx);
    case (idx)
      4'd0:    step_tag = 8'h0b;
      4'd1:    step_tag = 8'h0a;
      4'd2:    step_tag = 8'h09;
      4'd3:    step_tag = 8'h08;
      4'd4:    step_tag = 8'h3f;
      4'd5:    step_tag = 8'h1f;
      4'd6:    step_tag = 8'h0f;
      4'd7:    step_tag = 8'h07;
      4'd8:    step_tag = 8'haa;
      default: step_tag = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/geo_probe_seq.sv
module geo_probe_seq
  import geo_probe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              done,
  output logic              verify_fail,
  output logic [DATA_W-1:0] bank_word,
  output logic [DATA_W-1:0] row_word,
  output logic [DATA_W-1:0] col_word
);

  localparam int LANES = DATA_W / 8;
  localparam logic [STEP_W-1:0] LAST_VERIFY = STEP_W'(NUM_VERIFY - 1);
  localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(NUM_STEPS - 1);
  localparam logic [STEP_W-1:0] BANK_STEP   = STEP_W'(NUM_VERIFY);
  localparam logic [STEP_W-1:0] ROW_STEP    = STEP_W'(NUM_VERIFY + 1);

  probe_state_e      state;
  logic [STEP_W-1:0] step;
  logic [DATA_W-1:0] tag_word;
  logic              xfer;
  logic              in_verify;
  logic              mismatch;

  assign tag_word  = {LANES{step_tag(step)}};
  assign mem_req   = (state == PS_WRITE) || (state == PS_READ);
  assign mem_we    = (state == PS_WRITE);
  assign mem_addr  = step_addr(step);
  assign mem_wdata = tag_word;
  assign xfer      = mem_req && mem_ready;
  assign in_verify = (step <= LAST_VERIFY);
  assign mismatch  = (state == PS_READ) && xfer && in_verify && (mem_rdata != tag_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PS_IDLE;
      step        <= '0;
      done        <= 1'b0;
      verify_fail <= 1'b0;
      bank_word   <= '0;
      row_word    <= '0;
      col_word    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        PS_IDLE: if (start) begin
          step        <= '0;
          verify_fail <= 1'b0;
          state       <= PS_WRITE;
        end
        PS_WRITE: if (mem_ready) state <= PS_READ;
        PS_READ: if (mem_ready) begin
          if (in_verify) begin
            if (mismatch) begin
              verify_fail <= 1'b1;
              state       <= PS_DONE;
            end else begin
              step  <= step + 1'b1;
              state <= (step == LAST_VERIFY) ? PS_READ : PS_WRITE;
            end
          end else begin
            if (step == BANK_STEP)     bank_word <= mem_rdata;
            else if (step == ROW_STEP) row_word  <= mem_rdata;
            else                       col_word  <= mem_rdata;
            if (step == LAST_STEP) state <= PS_DONE;
            else                   step  <= step + 1'b1;
          end
        end
        PS_DONE: begin
          done  <= 1'b1;
          state <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  // R2: a stalled request keeps its command fields
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R3: a failed read-back ends bus activity
  assert_abort_R3: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> !mem_req);

endmodule

// File: rtl/geo_probe_decode.sv
module geo_probe_decode #(
  parameter int DATA_W = 32
) (
  input  logic              verify_fail,
  input  logic [DATA_W-1:0] bank_word,
  input  logic [DATA_W-1:0] row_word,
  input  logic [DATA_W-1:0] col_word,
  output logic              bad,
  output logic [3:0]        cfg,
  output logic [7:0]        end_addr
);

  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] TWO_BANK_TAG = {LANES{8'haa}};
  localparam logic [DATA_W-1:0] ROW_LO       = {LANES{8'h07}};
  localparam logic [DATA_W-1:0] ROW_MID      = {LANES{8'h0f}};
  localparam logic [DATA_W-1:0] ROW_HI       = {LANES{8'h3f}};
  localparam logic [DATA_W-1:0] COL_LO       = {LANES{8'h08}};
  localparam logic [DATA_W-1:0] COL_HI       = {LANES{8'h0b}};

  logic [LANES-1:0] row_lane_eq, col_lane_eq;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign row_lane_eq[g] = (row_word[8*g +: 8] == row_word[7:0]);
      assign col_lane_eq[g] = (col_word[8*g +: 8] == col_word[7:0]);
    end
  endgenerate

  logic two_bank, four_bank, bank_ok, row_ok, col_ok;
  logic [7:0] row_shifted;

  always_comb begin
    two_bank    = (bank_word == TWO_BANK_TAG);
    four_bank   = (bank_word == ROW_LO) || (bank_word == ROW_MID);
    bank_ok     = two_bank || four_bank;
    row_ok      = (row_word >= ROW_LO) && (row_word <= ROW_HI) && (&row_lane_eq);
    col_ok      = (col_word >= COL_LO) && (col_word <= COL_HI) && (&col_lane_eq);
    row_shifted = four_bank ? (row_word[7:0] >> 2) : (row_word[7:0] >> 3);
    bad         = verify_fail || !bank_ok || !row_ok || !col_ok;
    // column byte is 0x08..0x0b here, so its low two bits equal byte - 8
    cfg         = bad ? 4'h0 : {four_bank, 1'b0, col_word[1:0]};
    end_addr    = bad ? 8'h00 : (row_shifted + 8'd1);
  end

endmodule

// File: rtl/geo_probe.sv
module geo_probe
  import geo_probe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              result_valid,
  output logic              bad,
  output logic [3:0]        cfg_nibble,
  output logic [7:0]        end_byte
);

  logic              done, verify_fail, dec_bad;
  logic [DATA_W-1:0] bank_word, row_word, col_word;
  logic [3:0]        dec_cfg;
  logic [7:0]        dec_end;

  geo_probe_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .verify_fail(verify_fail),
    .bank_word(bank_word), .row_word(row_word), .col_word(col_word)
  );

  geo_probe_decode #(.DATA_W(DATA_W)) u_dec (
    .verify_fail(verify_fail), .bank_word(bank_word),
    .row_word(row_word), .col_word(col_word),
    .bad(dec_bad), .cfg(dec_cfg), .end_addr(dec_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      bad          <= 1'b0;
      cfg_nibble   <= 4'h0;
      end_byte     <= 8'h00;
    end else begin
      result_valid <= done;
      if (done) begin
        bad        <= dec_bad;
        cfg_nibble <= dec_cfg;
        end_byte   <= dec_end;
      end
    end
  end

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !mem_req);

  assert_bad_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (result_valid && bad) |-> (cfg_nibble == 4'h0 && end_byte == 8'h00));

  assert_good_fields_R7: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !bad) |-> (!cfg_nibble[2] && end_byte != 8'h00));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (rst)
    !result_valid |=> (result_valid || ($stable(bad) && $stable(cfg_nibble) && $stable(end_byte))));

endmodule

// File: tb/sim_geo_probe.sv
module sim_geo_probe;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        result_valid, bad;
  logic [3:0]  cfg_nibble;
  logic [7:0]  end_byte;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  geo_probe u0 (
    .clk(clk), .rst(rst), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .result_valid(result_valid), .bad(bad),
    .cfg_nibble(cfg_nibble), .end_byte(end_byte)
  );

  // Expected sequence, from R1
  logic [31:0] exp_addr [0:11];
  logic [31:0] exp_tag  [0:8];
  initial begin
    exp_addr[0] = 32'h0e001e00; exp_tag[0] = 32'h0b0b0b0b;
    exp_addr[1] = 32'h0e000e00; exp_tag[1] = 32'h0a0a0a0a;
    exp_addr[2] = 32'h0e000600; exp_tag[2] = 32'h09090909;
    exp_addr[3] = 32'h0e000200; exp_tag[3] = 32'h08080808;
    exp_addr[4] = 32'h0f000000; exp_tag[4] = 32'h3f3f3f3f;
    exp_addr[5] = 32'h07000000; exp_tag[5] = 32'h1f1f1f1f;
    exp_addr[6] = 32'h03000000; exp_tag[6] = 32'h0f0f0f0f;
    exp_addr[7] = 32'h01000000; exp_tag[7] = 32'h07070707;
    exp_addr[8] = 32'h00000000; exp_tag[8] = 32'haaaaaaaa;
    exp_addr[9] = 32'h03000000; exp_addr[10] = 32'h0f000000; exp_addr[11] = 32'h0e001e00;
  end

  // Aliasing memory model and transfer log
  logic [31:0] keep_mask = 32'hffffffff;
  logic        inj_en = 1'b0;
  int          inj_idx = 0;
  logic [31:0] inj_val = '0;
  logic        clr = 1'b0;
  logic        fast = 1'b0;
  logic [31:0] wl_addr [0:31];
  logic [31:0] wl_data [0:31];
  logic [31:0] tl_addr [0:31];
  logic [31:0] tl_data [0:31];
  logic        tl_we   [0:31];
  int          wcount = 0, rcount = 0, tcount = 0;
  logic [7:0]  lfsr = 8'h5a;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;
  logic        prev_we = 1'b0;
  int          r2_checks = 0, r2_fails = 0;

  function automatic logic [31:0] mem_lookup(input logic [31:0] a);
    logic [31:0] v = 32'h0;
    for (int j = 0; j < wcount; j++)
      if ((wl_addr[j] & keep_mask) == (a & keep_mask)) v = wl_data[j];
    return v;
  endfunction

  always_comb begin
    mem_ready = fast | lfsr[0] | lfsr[3];
    mem_rdata = (inj_en && rcount == inj_idx) ? inj_val : mem_lookup(mem_addr);
  end

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst && prev_stall) begin  // R2 monitor
      r2_checks++;
      if (!(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wdata)) begin
        r2_fails++;
        $display("FAIL R2 stalled request changed: addr %h we %b, expected addr %h we %b",
                 mem_addr, mem_we, prev_addr, prev_we);
      end
    end
    prev_stall <= !rst && mem_req && !mem_ready;
    prev_addr  <= mem_addr;
    prev_we    <= mem_we;
    prev_wdata <= mem_wdata;
    if (clr) begin
      wcount <= 0; rcount <= 0; tcount <= 0;
    end else if (!rst && mem_req && mem_ready) begin
      if (tcount < 32) begin
        tl_addr[tcount] <= mem_addr; tl_data[tcount] <= mem_wdata; tl_we[tcount] <= mem_we;
      end
      tcount <= tcount + 1;
      if (mem_we) begin
        wl_addr[wcount] <= mem_addr; wl_data[wcount] <= mem_wdata; wcount <= wcount + 1;
      end else rcount <= rcount + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent model of the rules R4..R9
  function automatic logic [12:0] rules(input logic [31:0] bw, rw, cw, input logic vfail);
    logic two, four, ok;
    logic [7:0] rb, e;
    two  = (bw == 32'haaaaaaaa);
    four = (bw == 32'h07070707) || (bw == 32'h0f0f0f0f);
    rb   = rw[7:0];
    ok   = !vfail && (two || four)
        && rw >= 32'h07070707 && rw <= 32'h3f3f3f3f && rw == {4{rb}}
        && cw >= 32'h08080808 && cw <= 32'h0b0b0b0b && cw == {4{cw[7:0]}};
    e    = (four ? (rb / 4) : (rb / 8)) + 8'd1;
    if (!ok) return 13'h1000;
    return {1'b0, four, 1'b0, 2'(cw[7:0] - 8'h08), e};
  endfunction

  // Value seen by a read: last aliasing write so far, unless injected
  function automatic logic [31:0] model_read(input int ridx, input logic [31:0] a, input int nw);
    logic [31:0] v = 32'h0;
    if (inj_en && ridx == inj_idx) return inj_val;
    for (int j = 0; j < nw; j++)
      if ((exp_addr[j] & keep_mask) == (a & keep_mask)) v = exp_tag[j];
    return v;
  endfunction

  task automatic run_probe(input string name);
    int vfail_at = -1;
    int n_exp, waitc, pulses;
    logic [31:0] bw, rw, cw;
    logic [12:0] r;
    logic ok_seq;
    for (int k = 0; k < 9; k++)
      if (vfail_at < 0 && model_read(k, exp_addr[k], k + 1) != exp_tag[k]) vfail_at = k;
    bw = model_read(9, exp_addr[9], 9);
    rw = model_read(10, exp_addr[10], 9);
    cw = model_read(11, exp_addr[11], 9);
    r  = rules(bw, rw, cw, vfail_at >= 0);
    n_exp = (vfail_at >= 0) ? 2 * (vfail_at + 1) : 21;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitc = 0;
    while (!result_valid && waitc < 2000) begin @(negedge clk); waitc++; end
    check({name, " R10 result_valid seen"}, 32'(result_valid), 32'h1);
    check({name, " R4 R5 R6 bad"}, 32'(bad), 32'(r[12]));
    check({name, " R7 cfg_nibble"}, 32'(cfg_nibble), 32'(r[11:8]));
    check({name, " R8 end_byte"}, 32'(end_byte), 32'(r[7:0]));
    if (bad) check({name, " R9 zero fields"}, {cfg_nibble, end_byte}, 32'h0);
    pulses = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (result_valid) pulses++;
      if (mem_req) pulses += 100;
    end
    check({name, " R10 single pulse, bus idle"}, 32'(pulses), 32'h0);
    check({name, " R10 held bad"}, 32'(bad), 32'(r[12]));
    check({name, " R3 transfer count"}, 32'(tcount), 32'(n_exp));
    ok_seq = 1'b1;
    for (int t = 0; t < n_exp && t < 32; t++) begin
      int s = (t < 18) ? t / 2 : t - 9;
      logic we_e = (t < 18) && (t % 2 == 0);
      if (tl_addr[t] != exp_addr[s] || tl_we[t] != we_e || (we_e && tl_data[t] != exp_tag[s])) ok_seq = 1'b0;
    end
    check({name, " R1 transfer order"}, 32'(ok_seq), 32'h1);
  endtask

  function automatic logic [31:0] geo_mask(input int c, input int rr, input int b);
    logic [31:0] m = 32'hffffffff;
    if (c < 9)   m[10] = 1'b0;
    if (c < 10)  m[11] = 1'b0;
    if (c < 11)  m[12] = 1'b0;
    if (rr < 14) m[27] = 1'b0;
    if (rr < 13) m[26] = 1'b0;
    if (rr < 12) m[25] = 1'b0;
    if (b == 2)  m[24] = 1'b0;
    return m;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 mem_req", 32'(mem_req), 32'h0);
    check("R11 result_valid", 32'(result_valid), 32'h0);
    check("R11 bad", 32'(bad), 32'h0);
    check("R11 cfg/end", {cfg_nibble, end_byte}, 32'h0);

    // Sweep every geometry of the aliasing model, with and without stalls
    for (int c = 8; c <= 11; c++)
      for (int rr = 11; rr <= 14; rr++)
        for (int b = 2; b <= 4; b += 2) begin
          keep_mask = geo_mask(c, rr, b);
          fast = ((c + rr + b) % 3 == 0);
          run_probe($sformatf("geo c%0d r%0d b%0d", c, rr, b));
        end

    // Injected read values at decision boundaries (full-decode memory)
    keep_mask = 32'hffffffff; fast = 1'b0; inj_en = 1'b1;
    inj_idx = 3;  inj_val = 32'h0;        run_probe("R3 verify miss pair3");
    inj_idx = 0;  inj_val = 32'h0b0b0b0a; run_probe("R3 verify miss pair0");
    inj_idx = 8;  inj_val = 32'h55555555; run_probe("R3 verify miss pair8");
    inj_idx = 9;  inj_val = 32'h07070707; run_probe("R4 bank row11 tag");
    inj_idx = 9;  inj_val = 32'haaaaaaaa; run_probe("R4 bank two");
    inj_idx = 9;  inj_val = 32'h1f1f1f1f; run_probe("R4 bank other");
    inj_idx = 10; inj_val = 32'h07070706; run_probe("R5 row below");
    inj_idx = 10; inj_val = 32'h3f3f3f40; run_probe("R5 row above");
    inj_idx = 10; inj_val = 32'h0f0f1f0f; run_probe("R5 row uneven");
    inj_idx = 10; inj_val = 32'h07070707; run_probe("R5 row low edge");
    inj_idx = 11; inj_val = 32'h08080808; run_probe("R6 col low edge");
    inj_idx = 11; inj_val = 32'h0c0c0c0c; run_probe("R6 col above");
    inj_idx = 11; inj_val = 32'h09090a09; run_probe("R6 col uneven");
    inj_idx = 11; inj_val = 32'h07070707; run_probe("R6 col below");
    inj_en = 1'b0;

    checks += r2_checks;
    fails  += r2_fails;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule